// File: doc/BRIEF.md
# I/O Port Address Mapper with Indirect Configuration Access

This block turns a 16-bit I/O port access into a physical request for the memory side of a core. It holds the 32-bit configuration-address register used by the classic two-port PCI configuration scheme. A full 32-bit access to the address port reads or writes that register. An access to any of the four data ports is steered into a configuration physical window, built from the stored register number and offset. This only happens while the register's enable bit (bit 31) is set. All remaining ports land in a flat I/O physical window at a fixed base plus the port number.

Requests enter on a valid/ready stream and leave one cycle later on a second valid/ready stream. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds every field unchanged and no new request is taken. Each response carries three things: the physical address, a flag marking an access to the internal register, and a drop flag for a data-port access made while the enable bit is clear. The bus transaction that follows is not part of this block.

Top module: `io_port_mapper`

## Requirements
- R1: After reset, `rsp_valid` is low and the configuration-address register holds zero; a 4-byte read of port 0xCF8 then returns 0.
- R2: A request with port 0xCF8 and `req_size` = 4 is internal: `rsp_internal`=1, `rsp_drop`=0, `rsp_paddr`=0, and a read returns the register in `rsp_rdata`.
- R3: A 4-byte write to port 0xCF8 stores `req_wdata` with bits 1:0 forced to zero; later reads return that value.
- R4: With register bit 31 set, a request to a port whose upper 14 bits equal those of 0xCFC (ports 0xCFC..0xCFF) yields `rsp_paddr` = CFG_BASE | {register[30:2], port[1:0]}, with both flags low.
- R5: With register bit 31 clear, a data-port request yields `rsp_drop`=1, `rsp_internal`=0, `rsp_paddr`=0. A read returns all ones, and a write leaves the register unchanged.
- R6: Every other request, including port 0xCF8 with `req_size` of 1 or 2, yields `rsp_paddr` = IO_BASE | port with both flags low, and never changes the register.
- R7: `rsp_rdata` is zero for every response other than an internal read or a dropped read.
- R8: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, all response fields stay stable and no request is taken.
- R9: An accepted request produces its response with `rsp_valid` high at the next clock edge. The response is computed from the register value as it stood before that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_port | input | 16 | I/O port number |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response can be taken |
| rsp_paddr | output | PA_W | Physical address |
| rsp_internal | output | 1 | Access targeted the configuration-address register |
| rsp_drop | output | 1 | Data-port access with enable clear; no bus access |
| rsp_rdata | output | 32 | Read data for internal or dropped reads |

## Verification
The bench uses the default parameters: a 40-bit physical address, an I/O base of 0x10_0000_0000 and a configuration base of 0x20_0000_0000. Because the two bases sit on distinct bits above bit 31, a swapped window, a missing OR term or a lost port field shows up in the address. The 32-bit register value shows in full through readback, so the forced-zero low bits and the enable bit can be checked directly. Random port picks are weighted toward 0xCF8..0xCFF, which brings the size-4 filter on the address port and the enable gate on the data ports into frequent reach.

// File: rtl/iopm_pkg.sv
package iopm_pkg;
  // Address and data ports of the two-port configuration scheme
  localparam logic [15:0] CFG_ADDR_PORT = 16'hCF8;
  localparam logic [15:0] CFG_DATA_PORT = 16'hCFC;
  localparam logic [2:0]  CFG_ADDR_SIZE = 3'd4;

  typedef enum logic [1:0] {
    ROUTE_FLAT    = 2'd0,
    ROUTE_CFG_REG = 2'd1,
    ROUTE_CFG_WIN = 2'd2,
    ROUTE_DROP    = 2'd3
  } route_e;
endpackage

// File: rtl/iopm_decode.sv
module iopm_decode
  import iopm_pkg::*;
#(
  parameter int          PA_W     = 40,
  parameter logic [PA_W-1:0] IO_BASE  = 40'h10_0000_0000,
  parameter logic [PA_W-1:0] CFG_BASE = 40'h20_0000_0000
) (
  input  logic [15:0]     port,
  input  logic [2:0]      size,
  input  logic [31:0]     cfg_addr,
  output route_e          route,
  output logic [PA_W-1:0] paddr
);
  localparam int WIN_W = 31;

  logic addr_hit;
  logic data_hit;
  logic [WIN_W-1:0] win_off;

  assign addr_hit = (port == CFG_ADDR_PORT) && (size == CFG_ADDR_SIZE);
  assign data_hit = (port[15:2] == CFG_DATA_PORT[15:2]);
  assign win_off  = {cfg_addr[30:2], port[1:0]};

  always_comb begin
    route = ROUTE_FLAT;
    paddr = IO_BASE | PA_W'(port);
    if (addr_hit) begin
      route = ROUTE_CFG_REG;
      paddr = '0;
    end else if (data_hit) begin
      if (cfg_addr[31]) begin
        route = ROUTE_CFG_WIN;
        paddr = CFG_BASE | PA_W'(win_off);
      end else begin
        route = ROUTE_DROP;
        paddr = '0;
      end
    end
  end
endmodule

// File: rtl/iopm_cfg_reg.sv
module iopm_cfg_reg #(
  parameter int REG_W  = 32,
  parameter int ZERO_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] value
);
  logic [REG_W-ZERO_W-1:0] upper_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     upper_q <= '0;
    else if (wr_en) upper_q <= wr_data[REG_W-1:ZERO_W];
  end

  assign value = {upper_q, {ZERO_W{1'b0}}};
endmodule

// File: rtl/iopm_out_stage.sv
module iopm_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/io_port_mapper.sv
module io_port_mapper
  import iopm_pkg::*;
#(
  parameter int              PA_W     = 40,
  parameter logic [PA_W-1:0] IO_BASE  = 40'h10_0000_0000,
  parameter logic [PA_W-1:0] CFG_BASE = 40'h20_0000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [15:0]     req_port,
  input  logic [2:0]      req_size,
  input  logic            req_write,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_internal,
  output logic            rsp_drop,
  output logic [31:0]     rsp_rdata
);
  localparam int DATA_W = 32;
  localparam int PAY_W  = PA_W + 2 + DATA_W;

  logic [DATA_W-1:0] cfg_val;
  route_e            route;
  logic [PA_W-1:0]   map_addr;
  logic              accept;
  logic              cfg_wr;
  logic [DATA_W-1:0] rdata_d;
  logic [PAY_W-1:0]  pay_d;
  logic [PAY_W-1:0]  pay_q;

  iopm_decode #(.PA_W(PA_W), .IO_BASE(IO_BASE), .CFG_BASE(CFG_BASE)) u_dec (
    .port     (req_port),
    .size     (req_size),
    .cfg_addr (cfg_val),
    .route    (route),
    .paddr    (map_addr)
  );

  assign accept = req_valid && req_ready;
  assign cfg_wr = accept && req_write && (route == ROUTE_CFG_REG);

  iopm_cfg_reg #(.REG_W(DATA_W), .ZERO_W(2)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (req_wdata),
    .value   (cfg_val)
  );

  always_comb begin
    rdata_d = '0;
    if (!req_write) begin
      if (route == ROUTE_CFG_REG)   rdata_d = cfg_val;
      else if (route == ROUTE_DROP) rdata_d = '1;
    end
  end

  assign pay_d = {map_addr, (route == ROUTE_CFG_REG), (route == ROUTE_DROP), rdata_d};

  iopm_out_stage #(.DW(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_d),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pay_q)
  );

  assign {rsp_paddr, rsp_internal, rsp_drop, rsp_rdata} = pay_q;

  // R5
  drop_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_drop) |-> (rsp_paddr == '0 && !rsp_internal));

  // R2
  internal_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_internal) |-> (rsp_paddr == '0 && !rsp_drop));

  // R6
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && req_write && req_port == CFG_ADDR_PORT && req_size == CFG_ADDR_SIZE)
      |=> $stable(cfg_val));

  // R3
  cfg_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_internal) |-> (rsp_rdata[1:0] == 2'b00));
endmodule

// File: tb/sim_io_port_mapper.sv
`timescale 1ns/1ps
module sim_io_port_mapper;
  localparam int              PA_W     = 40;
  localparam logic [PA_W-1:0] IO_BASE  = 40'h10_0000_0000;
  localparam logic [PA_W-1:0] CFG_BASE = 40'h20_0000_0000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [15:0]     req_port = '0;
  logic [2:0]      req_size = 3'd1;
  logic            req_write = 1'b0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [PA_W-1:0] rsp_paddr;
  logic            rsp_internal;
  logic            rsp_drop;
  logic [31:0]     rsp_rdata;

  int errors = 0;
  int checks = 0;
  logic [31:0] model_cfg = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  io_port_mapper #(.PA_W(PA_W), .IO_BASE(IO_BASE), .CFG_BASE(CFG_BASE)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_internal(rsp_internal), .rsp_drop(rsp_drop), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected response {paddr, internal, drop, rdata}; updates the model register
  function automatic logic [PA_W+33:0] expect_rsp(input logic [15:0] p, input logic [2:0] s,
                                                   input bit w, input logic [31:0] wd);
    logic [PA_W-1:0] a;
    bit in_f, dr_f;
    logic [31:0] rd;
    a = IO_BASE | {{(PA_W-16){1'b0}}, p};
    in_f = 0; dr_f = 0; rd = '0;
    if (p == 16'hCF8 && s == 3'd4) begin
      a = '0; in_f = 1;
      if (!w) rd = model_cfg;
      else model_cfg = {wd[31:2], 2'b00};
    end else if (p[15:2] == 14'h033F) begin
      if (model_cfg[31]) begin
        a = CFG_BASE | {{(PA_W-31){1'b0}}, model_cfg[30:2], p[1:0]};
      end else begin
        a = '0; dr_f = 1;
        if (!w) rd = 32'hFFFF_FFFF;
      end
    end
    return {a, in_f, dr_f, rd};
  endfunction

  function automatic string tag_of(input logic [15:0] p, input logic [2:0] s, input logic [31:0] c);
    if (p == 16'hCF8 && s == 3'd4) return "R2/R3/R7";
    if (p[15:2] == 14'h033F) return c[31] ? "R4/R7/R9" : "R5";
    return "R6/R7";
  endfunction

  task automatic xact(input logic [15:0] p, input logic [2:0] s, input bit w, input logic [31:0] wd);
    logic [PA_W+33:0] exp;
    string tg;
    tg = tag_of(p, s, model_cfg);
    @(negedge clk);
    req_valid = 1; req_port = p; req_size = s; req_write = w; req_wdata = wd;
    exp = expect_rsp(p, s, w, wd);
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid === 1'b1, "R9 valid", {127'd0, rsp_valid}, 128'd1);
    check({rsp_paddr, rsp_internal, rsp_drop, rsp_rdata} === exp, tg,
          {rsp_paddr, rsp_internal, rsp_drop, rsp_rdata}, exp);
  endtask

  function automatic logic [15:0] pick_port(input int r);
    case (r % 6)
      0: return 16'hCF8;
      1: return 16'hCFC | 16'(r[5:4]);
      2: return 16'hCF8 | 16'(r[5:4]);
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [2:0] pick_size(input int r);
    case (r % 3)
      0: return 3'd1;
      1: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [PA_W+33:0] e1, e2;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rsp_valid === 1'b0, "R1 valid in reset", {127'd0, rsp_valid}, 128'd0);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 idle after reset",
          {126'd0, rsp_valid, req_ready}, 128'd1);
    xact(16'hCF8, 3'd4, 0, 0); // R1 register reads zero
    // R5 disabled data ports: read all ones, write dropped
    xact(16'hCFD, 3'd1, 0, 0);
    xact(16'hCFE, 3'd2, 1, 32'h1234_5678);
    xact(16'hCF8, 3'd4, 0, 0);
    // R3 low bits cleared on write
    xact(16'hCF8, 3'd4, 1, 32'h8012_3457);
    xact(16'hCF8, 3'd4, 0, 0);
    // R4 enabled window, all four data ports
    for (int i = 0; i < 4; i++) xact(16'hCFC + 16'(i), 3'd1, i[0], 32'hAA);
    // R6 narrow access to address port is flat and leaves register alone
    xact(16'hCF8, 3'd2, 1, 32'h0);
    xact(16'hCF8, 3'd1, 0, 0);
    xact(16'hCF8, 3'd4, 0, 0);
    xact(16'hCFB, 3'd4, 0, 0);
    xact(16'hFFFF, 3'd4, 1, 32'h5);
    xact(16'h0000, 3'd1, 0, 0);

    // R8 back-pressure: hold first response, refuse second request
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_port = 16'hCFF; req_size = 3'd1; req_write = 0;
    e1 = expect_rsp(16'hCFF, 3'd1, 0, 0);
    @(negedge clk);
    req_port = 16'hCF8; req_size = 3'd4; req_write = 1; req_wdata = 32'h0000_0100;
    check(req_ready === 1'b0, "R8 ready low", {127'd0, req_ready}, 128'd0);
    repeat (3) begin
      @(negedge clk);
      check(rsp_valid === 1'b1 && {rsp_paddr, rsp_internal, rsp_drop, rsp_rdata} === e1,
            "R8 hold", {rsp_paddr, rsp_internal, rsp_drop, rsp_rdata}, e1);
    end
    rsp_ready = 1;
    e2 = expect_rsp(16'hCF8, 3'd4, 1, 32'h0000_0100);
    @(negedge clk);
    req_valid = 0;
    check({rsp_paddr, rsp_internal, rsp_drop, rsp_rdata} === e2, "R8 next after release",
          {rsp_paddr, rsp_internal, rsp_drop, rsp_rdata}, e2);
    xact(16'hCF8, 3'd4, 0, 0);
    xact(16'hCFC, 3'd4, 0, 0); // R5 enable now clear

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [31:0] wd;
      r = int'($urandom_range(0, 9999));
      wd = $urandom;
      xact(pick_port(r), pick_size(r / 7), r[3], wd);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule